// File: doc/BRIEF.md
# Chained Descriptor DMA Channel

This block is a single DMA channel controller. It copies a byte count from a source region to a destination region through a 64-byte staging buffer. It reaches memory through a request/acknowledge port with a 64-bit data bus and per-byte enables. Work is split into bursts. Each burst reads up to a buffer's worth of bytes from the source into the stage, then writes those bytes to the destination. Bursts repeat until the remaining count reaches zero.

Each side has its own address stepping rule: up, down, or fixed. Either address may start on any byte. A transfer starts on a software start strobe, an external request line, or a timer pulse. In unchained mode the count and the two addresses come from configuration inputs. In chained mode the channel fetches a 16-byte descriptor record from a head pointer. After each record completes, the channel writes the record's count word back with the owner flag cleared, then follows the link field to the next record. An end-of-transfer input cuts the current record short, and the bytes still owed are recorded in the write-back.

Top module: `dmac_channel`

## Requirements
- R1: After reset the channel is idle: `busy`, `mem_req`, `xfer_done` and `chain_done` are all low.
- R2: While idle, a one-cycle high on any one of `sw_start`, `ext_req` or `tmr_pulse` starts a transfer. While `busy` is high, all three inputs are ignored: no extra record and no extra byte is moved.
- R3: Step mode 0 (increment) copies byte i of the transfer from source address S+i to destination address D+i. The number of destination byte writes equals the count, including counts larger than the 64-byte stage.
- R4: Step mode 1 (decrement) on a side uses address A-i for byte i.
- R5: Step modes 2 and 3 (hold) keep that side's address fixed. A held destination ends up holding the last source byte.
- R6: Every data write carries exactly one byte enable, in lane `mem_addr[2:0]`, with the byte replicated on all lanes. Bytes next to an unaligned start or end are left unchanged.
- R7: Once `mem_req` rises, it stays high with a stable address, direction and byte enables until the cycle `mem_ack` is seen.
- R8: A descriptor at 8-byte-aligned address P holds two 64-bit words. The word at P has the count in bits 30:0, the owner flag in bit 31, and the source address in bits 63:32. The word at P+8 has the destination address in bits 31:0 and the next-record pointer in bits 63:32. A next pointer of zero ends the chain.
- R9: In chained mode, each finished record is closed by one write to P with `mem_be` = 8'h0F. The write carries bit 31 cleared and the remaining count in bits 30:0, which is zero after a full transfer. Bits 63:32 of that word are left intact.
- R10: A high on `eot` during a transfer ends it before its next memory beat. The write-back count equals the original count minus the destination bytes actually written, and the chain stops there.
- R11: `xfer_done` is a one-cycle pulse for every finished transfer or record. In chained mode, `chain_done` pulses together with the last record's `xfer_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_chain | input | 1 | 1 = walk descriptor records from `cfg_head` |
| cfg_src_mode | input | 2 | Source step: 0 up, 1 down, 2/3 hold |
| cfg_dst_mode | input | 2 | Destination step: 0 up, 1 down, 2/3 hold |
| cfg_count | input | 31 | Byte count, unchained mode |
| cfg_src | input | 32 | Source start address, unchained mode |
| cfg_dst | input | 32 | Destination start address, unchained mode |
| cfg_head | input | 32 | First descriptor address, chained mode |
| sw_start | input | 1 | Software start strobe |
| ext_req | input | 1 | External request trigger |
| tmr_pulse | input | 1 | Timer trigger pulse |
| eot | input | 1 | End-of-transfer request |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write beat |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 8 | Byte enables for writes |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Beat accepted; read data valid |
| mem_rdata | input | 64 | Read data |
| busy | output | 1 | Channel active |
| xfer_done | output | 1 | Record/transfer finished pulse |
| chain_done | output | 1 | Chain finished pulse |

## Verification
The checker relies on three assumptions about the inputs. First, `mem_ack` is raised for exactly one cycle, and only while a request is pending. Second, the configuration inputs and descriptor memory do not change while the channel is busy. Third, source and destination regions do not overlap. The bench's memory model answers each request one cycle after it appears and drops the acknowledge on the next cycle. All sweep regions, descriptor records and stage contents are placed in disjoint windows of the model. Configuration is changed only while `busy` is low.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int BUS_BYTES = 8;
  localparam int CNT_BITS  = 31;

  typedef enum logic [1:0] {
    STEP_UP   = 2'd0,
    STEP_DOWN = 2'd1,
    STEP_HOLD = 2'd2
  } step_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESC0,
    ST_DESC1,
    ST_PLAN,
    ST_READ,
    ST_WRITE,
    ST_CLOSE
  } chan_st_e;
endpackage

// File: rtl/dmac_addr_step.sv
module dmac_addr_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur,
  input  logic [1:0]    mode,
  output logic [AW-1:0] nxt
);
  import dmac_pkg::*;

  always_comb begin
    case (mode)
      STEP_UP:   nxt = cur + AW'(1);
      STEP_DOWN: nxt = cur - AW'(1);
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/dmac_stage_buf.sv
module dmac_stage_buf #(
  parameter int DEPTH = 64,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/dmac_channel.sv
module dmac_channel #(
  parameter int BUF_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_chain,
  input  logic [1:0]  cfg_src_mode,
  input  logic [1:0]  cfg_dst_mode,
  input  logic [30:0] cfg_count,
  input  logic [31:0] cfg_src,
  input  logic [31:0] cfg_dst,
  input  logic [31:0] cfg_head,
  input  logic        sw_start,
  input  logic        ext_req,
  input  logic        tmr_pulse,
  input  logic        eot,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [7:0]  mem_be,
  output logic [63:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [63:0] mem_rdata,
  output logic        busy,
  output logic        xfer_done,
  output logic        chain_done
);
  import dmac_pkg::*;

  localparam int IW = $clog2(BUF_BYTES);
  localparam int BW = IW + 1;
  localparam int LW = $clog2(BUS_BYTES);

  chan_st_e            st;
  logic [CNT_BITS-1:0] cnt;
  logic [31:0]         src, dst, link, cur_ptr;
  logic [BW-1:0]       idx, blen;
  logic                stop_q, chain_q;
  logic [1:0]          smode, dmode;

  logic [31:0]   src_nx, dst_nx;
  logic [7:0]    stage_rd, lane_byte;
  logic [BW-1:0] blen_nx;
  logic          trig, beat_done;

  dmac_addr_step #(.AW(32)) u_src_step (.cur(src), .mode(smode), .nxt(src_nx));
  dmac_addr_step #(.AW(32)) u_dst_step (.cur(dst), .mode(dmode), .nxt(dst_nx));

  dmac_stage_buf #(.DEPTH(BUF_BYTES)) u_stage (
    .clk  (clk),
    .we   (st == ST_READ && mem_req && mem_ack),
    .waddr(idx[IW-1:0]),
    .wdata(lane_byte),
    .raddr(idx[IW-1:0]),
    .rdata(stage_rd)
  );

  assign trig      = sw_start | ext_req | tmr_pulse;
  assign beat_done = mem_req & mem_ack;
  assign lane_byte = mem_rdata[8*src[LW-1:0] +: 8];
  assign blen_nx   = (cnt >= CNT_BITS'(BUF_BYTES)) ? BW'(BUF_BYTES) : cnt[BW-1:0];
  assign busy      = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      mem_req <= 1'b0;
      mem_we <= 1'b0;
      mem_addr <= '0;
      mem_be <= '0;
      mem_wdata <= '0;
      cnt <= '0;
      src <= '0;
      dst <= '0;
      link <= '0;
      cur_ptr <= '0;
      idx <= '0;
      blen <= '0;
      stop_q <= 1'b0;
      chain_q <= 1'b0;
      smode <= '0;
      dmode <= '0;
      xfer_done <= 1'b0;
      chain_done <= 1'b0;
    end else begin
      xfer_done <= 1'b0;
      chain_done <= 1'b0;
      if (eot && (st == ST_READ || st == ST_WRITE)) stop_q <= 1'b1;
      case (st)
        ST_IDLE: if (trig) begin
          stop_q <= 1'b0;
          chain_q <= cfg_chain;
          smode <= cfg_src_mode;
          dmode <= cfg_dst_mode;
          if (cfg_chain) begin
            cur_ptr <= cfg_head;
            st <= ST_DESC0;
          end else begin
            cnt <= cfg_count;
            src <= cfg_src;
            dst <= cfg_dst;
            st <= ST_PLAN;
          end
        end
        ST_DESC0: begin
          if (beat_done) begin
            mem_req <= 1'b0;
            cnt <= mem_rdata[CNT_BITS-1:0];
            src <= mem_rdata[63:32];
            st <= ST_DESC1;
          end else if (!mem_req) begin
            mem_req <= 1'b1;
            mem_we <= 1'b0;
            mem_addr <= cur_ptr;
          end
        end
        ST_DESC1: begin
          if (beat_done) begin
            mem_req <= 1'b0;
            dst <= mem_rdata[31:0];
            link <= mem_rdata[63:32];
            st <= ST_PLAN;
          end else if (!mem_req) begin
            mem_req <= 1'b1;
            mem_we <= 1'b0;
            mem_addr <= cur_ptr + 32'd8;
          end
        end
        ST_PLAN: begin
          idx <= '0;
          blen <= blen_nx;
          if (cnt == '0) begin
            st <= chain_q ? ST_CLOSE : ST_IDLE;
            xfer_done <= !chain_q;
          end else begin
            st <= ST_READ;
          end
        end
        ST_READ: begin
          if (beat_done) begin
            mem_req <= 1'b0;
            idx <= idx + BW'(1);
            src <= src_nx;
          end else if (!mem_req) begin
            if (stop_q) begin
              st <= chain_q ? ST_CLOSE : ST_IDLE;
              xfer_done <= !chain_q;
            end else if (idx == blen) begin
              idx <= '0;
              st <= ST_WRITE;
            end else begin
              mem_req <= 1'b1;
              mem_we <= 1'b0;
              mem_addr <= src;
            end
          end
        end
        ST_WRITE: begin
          if (beat_done) begin
            mem_req <= 1'b0;
            mem_we <= 1'b0;
            idx <= idx + BW'(1);
            dst <= dst_nx;
            cnt <= cnt - CNT_BITS'(1);
          end else if (!mem_req) begin
            if (stop_q) begin
              st <= chain_q ? ST_CLOSE : ST_IDLE;
              xfer_done <= !chain_q;
            end else if (idx == blen) begin
              st <= ST_PLAN;
            end else begin
              mem_req <= 1'b1;
              mem_we <= 1'b1;
              mem_addr <= dst;
              mem_be <= 8'(1) << dst[LW-1:0];
              mem_wdata <= {BUS_BYTES{stage_rd}};
            end
          end
        end
        ST_CLOSE: begin
          if (beat_done) begin
            mem_req <= 1'b0;
            mem_we <= 1'b0;
            xfer_done <= 1'b1;
            if (stop_q || link == '0) begin
              chain_done <= 1'b1;
              st <= ST_IDLE;
            end else begin
              cur_ptr <= link;
              st <= ST_DESC0;
            end
          end else if (!mem_req) begin
            mem_req <= 1'b1;
            mem_we <= 1'b1;
            mem_addr <= cur_ptr;
            mem_be <= 8'h0F;
            mem_wdata <= {32'h0, 1'b0, cnt};
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmac_channel_chk.sv
module dmac_channel_chk (
  input logic        clk,
  input logic        rst,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [7:0]  mem_be,
  input logic        busy,
  input logic        xfer_done,
  input logic        chain_done,
  input logic        chain_q
);
  a_r7_req_held: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_be));

  a_r6_one_lane: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> ($onehot(mem_be) || mem_be == 8'h0F));

  a_r6_lane_matches: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we && $onehot(mem_be) |-> mem_be[mem_addr[2:0]]);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done);

  a_r11_chain_with_done: assert property (@(posedge clk) disable iff (rst)
    chain_done |-> xfer_done && chain_q);
endmodule

bind dmac_channel dmac_channel_chk u_chk (.*);

// File: tb/dmac_channel_tb_top.sv
module dmac_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_chain = 1'b0;
  logic [1:0]  cfg_src_mode = '0, cfg_dst_mode = '0;
  logic [30:0] cfg_count = '0;
  logic [31:0] cfg_src = '0, cfg_dst = '0, cfg_head = '0;
  logic        sw_start = 1'b0, ext_req = 1'b0, tmr_pulse = 1'b0, eot = 1'b0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata, mem_rdata;
  logic        busy, xfer_done, chain_done;

  int vectors = 0, misses = 0;
  int wr_beats = 0, done_cnt = 0, chain_cnt = 0;
  logic [63:0] mem [0:511];

  always #5 clk = ~clk;

  dmac_channel dut_i (.*);

  // memory model: ack one cycle after a request, for one cycle
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      mem_rdata <= mem[mem_addr[11:3]];
      if (mem_we)
        for (int l = 0; l < 8; l++)
          if (mem_be[l]) mem[mem_addr[11:3]][l*8 +: 8] <= mem_wdata[l*8 +: 8];
    end else begin
      mem_ack <= 1'b0;
    end
  end

  always @(posedge clk) begin
    if (!rst && mem_req && mem_we && mem_ack && mem_be != 8'h0F) wr_beats <= wr_beats + 1;
    if (!rst && xfer_done) done_cnt <= done_cnt + 1;
    if (!rst && chain_done) chain_cnt <= chain_cnt + 1;
  end

  function automatic logic [7:0] pat(input logic [11:0] a);
    return 8'(a * 37 + 11);
  endfunction

  function automatic logic [7:0] rb(input logic [11:0] a);
    return mem[a[11:3]][a[2:0]*8 +: 8];
  endfunction

  function automatic logic [11:0] at(input logic [11:0] b, input int m, input int i);
    if (m == 0) return b + 12'(i);
    if (m == 1) return b - 12'(i);
    return b;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill_mem();
    for (int a = 0; a < 4096; a++) mem[a >> 3][(a % 8)*8 +: 8] = pat(12'(a));
  endtask

  task automatic fire(input int sel);
    @(negedge clk);
    if (sel == 0) sw_start = 1'b1; else if (sel == 1) ext_req = 1'b1; else tmr_pulse = 1'b1;
    @(negedge clk);
    sw_start = 1'b0; ext_req = 1'b0; tmr_pulse = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    if (busy) check(1'b0, "R2 channel hung", 1, 0);
  endtask

  task automatic run_sweep(input int sm, input int dm, input int len, input int sel);
    logic [11:0] s, d;
    int b0, d0, c0;
    s = 12'(((sm == 1) ? 12'h380 : 12'h330) + (sm * 3 + len) % 8);
    d = 12'(((dm == 1) ? 12'h6C0 : 12'h680) + (dm * 5 + len + 1) % 8);
    fill_mem();
    cfg_chain = 1'b0; cfg_src_mode = 2'(sm); cfg_dst_mode = 2'(dm);
    cfg_count = 31'(len); cfg_src = 32'(s); cfg_dst = 32'(d);
    b0 = wr_beats; d0 = done_cnt; c0 = chain_cnt;
    fire(sel);
    check(busy == 1'b1, "R2 start", busy, 1);
    repeat (6) @(negedge clk);
    fire((sel + 1) % 3);
    wait_idle();
    repeat (8) @(negedge clk);
    check(busy == 1'b0, "R2 no restart while busy", busy, 0);
    check(wr_beats - b0 == len, "R3 write count", wr_beats - b0, len);
    check(done_cnt - d0 == 1 && chain_cnt == c0, "R11 single done", done_cnt - d0, 1);
    if (dm >= 2) begin
      check(rb(d) == pat(at(s, sm, len - 1)), "R5 held dst", rb(d), pat(at(s, sm, len - 1)));
      check(rb(d + 1) == pat(d + 1) && rb(d - 1) == pat(d - 1), "R6 hold guard", rb(d + 1), pat(d + 1));
    end else begin
      for (int i = 0; i < len; i++)
        check(rb(at(d, dm, i)) == pat(at(s, sm, i)), sm == 1 || dm == 1 ? "R4 data" : (sm >= 2 ? "R5 data" : "R3 data"),
              rb(at(d, dm, i)), pat(at(s, sm, i)));
      check(rb(at(d, dm, len)) == pat(at(d, dm, len)), "R6 end guard", rb(at(d, dm, len)), pat(at(d, dm, len)));
      check(rb(at(d, dm, -1)) == pat(at(d, dm, -1)), "R6 start guard", rb(at(d, dm, -1)), pat(at(d, dm, -1)));
    end
  endtask

  task automatic put_desc(input logic [11:0] p, input int len, input logic [11:0] s,
                          input logic [11:0] d, input logic [11:0] nx);
    mem[p >> 3] = {32'(s), 1'b1, 31'(len)};
    mem[(p >> 3) + 1] = {32'(nx), 32'(d)};
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    int d0, c0, b0, w;
    int lens [3] = '{1, 9, 70};
    logic [11:0] cs [3] = '{12'h203, 12'h240, 12'h2A1};
    logic [11:0] cd [3] = '{12'h905, 12'h950, 12'h9C2};
    int cl [3] = '{5, 64, 13};
    int run = 0;
    fill_mem();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!busy && !mem_req && !xfer_done && !chain_done, "R1 reset state",
          {busy, mem_req, xfer_done, chain_done}, 0);

    for (int sm = 0; sm < 3; sm++)
      for (int dm = 0; dm < 3; dm++)
        for (int k = 0; k < 3; k++) begin
          run_sweep(sm, dm, lens[k], run % 3);
          run++;
        end

    // R8 R9: chain of three records
    fill_mem();
    put_desc(12'h100, cl[0], cs[0], cd[0], 12'h120);
    put_desc(12'h120, cl[1], cs[1], cd[1], 12'h140);
    put_desc(12'h140, cl[2], cs[2], cd[2], 12'h000);
    cfg_chain = 1'b1; cfg_src_mode = 2'd0; cfg_dst_mode = 2'd0; cfg_head = 32'h100;
    d0 = done_cnt; c0 = chain_cnt;
    fire(2);
    wait_idle();
    repeat (4) @(negedge clk);
    for (int r = 0; r < 3; r++) begin
      logic [11:0] p;
      p = 12'h100 + 12'(r * 32);
      check(mem[p >> 3][31:0] == 32'h0, "R9 owner cleared count zero", mem[p >> 3][31:0], 0);
      check(mem[p >> 3][63:32] == 32'(cs[r]), "R9 upper word intact", mem[p >> 3][63:32], cs[r]);
      for (int i = 0; i < cl[r]; i++)
        check(rb(cd[r] + 12'(i)) == pat(cs[r] + 12'(i)), "R8 chained data", rb(cd[r] + 12'(i)), pat(cs[r] + 12'(i)));
      check(rb(cd[r] + 12'(cl[r])) == pat(cd[r] + 12'(cl[r])), "R6 chained guard",
            rb(cd[r] + 12'(cl[r])), pat(cd[r] + 12'(cl[r])));
    end
    check(done_cnt - d0 == 3, "R11 record pulses", done_cnt - d0, 3);
    check(chain_cnt - c0 == 1, "R11 chain pulse", chain_cnt - c0, 1);

    // R10: early end of transfer
    fill_mem();
    put_desc(12'h180, 200, 12'h400, 12'hA00, 12'h1A0);
    put_desc(12'h1A0, 4, 12'h500, 12'hB00, 12'h000);
    cfg_head = 32'h180;
    d0 = done_cnt; c0 = chain_cnt; b0 = wr_beats;
    fire(0);
    while (wr_beats - b0 < 20) @(negedge clk);
    eot = 1'b1;
    @(negedge clk);
    eot = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    w = wr_beats - b0;
    check(w >= 20 && w < 200, "R10 stopped early", w, 20);
    check(mem[12'h180 >> 3][31:0] == 32'(200 - w), "R10 remaining written back",
          mem[12'h180 >> 3][31:0], 200 - w);
    for (int i = 0; i < w; i++)
      check(rb(12'hA00 + 12'(i)) == pat(12'h400 + 12'(i)), "R10 data before stop",
            rb(12'hA00 + 12'(i)), pat(12'h400 + 12'(i)));
    check(rb(12'hA00 + 12'(w)) == pat(12'hA00 + 12'(w)), "R10 nothing after stop",
          rb(12'hA00 + 12'(w)), pat(12'hA00 + 12'(w)));
    check(mem[12'h1A0 >> 3][31] == 1'b1 && rb(12'hB00) == pat(12'hB00), "R10 chain halted",
          mem[12'h1A0 >> 3][31], 1);
    check(done_cnt - d0 == 1 && chain_cnt - c0 == 1, "R11 pulses after stop", done_cnt - d0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule